// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Pending Controller

This block holds the interrupt-pending state of a two-channel serial controller. Each channel has three sources: external/status, transmit and receive. Event pulses latch a pending bit for each source. A single status byte combines all six bits and is read combinationally through a channel-selected read port. Any pending bit raises one interrupt request line, gated by a master enable.

The transmit source has an extra control. A command code written to a channel can drop that channel's transmit pending bit and disarm transmit interrupts. The disarm lasts until software writes the next data byte to that channel. Software uses it at the end of a message, so that an empty transmitter with transmit interrupts still enabled does not request service again.

Channel index 0 is channel A and index 1 is channel B on every two-bit port.

Top module: `sio_irq_pending`

## Requirements
- R1: Read through channel A, the status byte holds channel B's external, transmit and receive pending bits at positions 0, 1 and 2. It holds channel A's external, transmit and receive pending bits at positions 3, 4 and 5. Bits 7 and 6 are always 0.
- R2: When `rd_chan` is 1 (a read through channel B), `status` is 8'h00 whatever is pending.
- R3: A command write (`cmd_wr`=1) with `cmd_code`=3'b101 does two things at the next clock edge, for the channel picked by `cmd_chan`: it clears that channel's transmit pending bit and it sets that channel's disarm latch. Any other code has no effect on pending bits or disarm state.
- R4: While a channel's disarm latch is set, a transmit-complete pulse does not set that channel's transmit pending bit.
- R5: A data write to a channel clears its disarm latch at the next edge. If a data write and a reset-transmit command reach the same channel in the same cycle, the latch ends up set.
- R6: A transmit-complete pulse sets the transmit pending bit at the next edge only when that channel's transmit enable is 1 and its disarm latch is 0.
- R7: A receive or external event pulse sets its pending bit at the next edge only when its enable is 1. The matching clear input clears it at the next edge.
- R8: When a set and a clear of the same pending bit fall in the same cycle, the bit is 0 after the edge.
- R9: `irq` is 1 exactly when `master_ie` is 1 and any pending bit is set. It changes in the same cycle as the pending bits it depends on.
- R10: After reset, all pending bits and both disarm latches are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_chan | input | 1 | Channel addressed by the command (0=A, 1=B) |
| cmd_code | input | 3 | Command field; 3'b101 resets transmit pending |
| data_wr | input | 2 | Per-channel transmit data write strobe |
| tx_done | input | 2 | Per-channel transmit-complete pulse |
| rx_evt | input | 2 | Per-channel receive event pulse |
| ext_evt | input | 2 | Per-channel external/status event pulse |
| tx_ie | input | 2 | Per-channel transmit interrupt enable |
| rx_ie | input | 2 | Per-channel receive interrupt enable |
| ext_ie | input | 2 | Per-channel external/status interrupt enable |
| rx_clr | input | 2 | Per-channel receive pending clear |
| ext_clr | input | 2 | Per-channel external pending clear |
| master_ie | input | 1 | Master interrupt enable |
| rd_chan | input | 1 | Channel the status read goes through (0=A, 1=B) |
| status | output | 8 | Packed pending status byte |
| irq | output | 1 | Interrupt request |

## Verification
A stuck or wrongly set disarm latch has no effect on `status` right away. It shows only at the next transmit-complete pulse on that channel: the transmit bit then stays low when it should rise, or rises when it should stay low. The bench therefore follows every command and data write with a transmit-complete pulse, and it checks the status byte one edge later. A wrong pending bit shows on `status` and `irq` right after the edge that stored it. A swapped channel or a wrong bit position shows in the first read where only one source is pending.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
  localparam int N_CH       = 2;
  localparam int CMD_W      = 3;
  localparam int STAT_W     = 8;
  localparam logic [CMD_W-1:0] CMD_RST_TX = 3'b101;

  // packed so that rx is the MSB: {rx, tx, ext}
  typedef struct packed {
    logic rx;
    logic tx;
    logic ext;
  } src_pend_t;

  localparam int SRC_W  = $bits(src_pend_t);
  localparam int SPARE_W = STAT_W - N_CH * SRC_W;

  function automatic logic [STAT_W-1:0] pack_status(src_pend_t a, src_pend_t b);
    return {{SPARE_W{1'b0}}, a, b};
  endfunction

  function automatic logic is_rst_tx(logic [CMD_W-1:0] code);
    return code == CMD_RST_TX;
  endfunction

  // one pending bit: set, then clear overrides
  function automatic logic next_bit(logic cur, logic set, logic clr);
    return clr ? 1'b0 : (set ? 1'b1 : cur);
  endfunction
endpackage

// File: rtl/sio_cmd_decode.sv
module sio_cmd_decode
  import sio_irq_pkg::*;
(
  input  logic             cmd_wr,
  input  logic             cmd_chan,
  input  logic [CMD_W-1:0] cmd_code,
  output logic [N_CH-1:0]  rst_tx_hit
);
  logic code_hit;
  assign code_hit = cmd_wr && is_rst_tx(cmd_code);

  for (genvar c = 0; c < N_CH; c++) begin : g_hit
    assign rst_tx_hit[c] = code_hit && (cmd_chan == 1'(c));
  end
endmodule

// File: rtl/sio_chan_pend.sv
module sio_chan_pend
  import sio_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tx_done,
  input  logic      tx_ie,
  input  logic      rx_evt,
  input  logic      rx_ie,
  input  logic      ext_evt,
  input  logic      ext_ie,
  input  logic      rx_clr,
  input  logic      ext_clr,
  input  logic      data_wr,
  input  logic      rst_tx,
  output src_pend_t pend,
  output logic      disarm
);
  src_pend_t pend_q;
  logic      disarm_q;

  // named internal events
  logic tx_set_ev, rx_set_ev, ext_set_ev;
  assign tx_set_ev  = tx_done && tx_ie && !disarm_q;
  assign rx_set_ev  = rx_evt && rx_ie;
  assign ext_set_ev = ext_evt && ext_ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      disarm_q <= 1'b0;
    end else begin
      pend_q.tx  <= next_bit(pend_q.tx,  tx_set_ev,  rst_tx);
      pend_q.rx  <= next_bit(pend_q.rx,  rx_set_ev,  rx_clr);
      pend_q.ext <= next_bit(pend_q.ext, ext_set_ev, ext_clr);
      // command after data write: command wins in the same cycle
      disarm_q   <= rst_tx ? 1'b1 : (data_wr ? 1'b0 : disarm_q);
    end
  end

  assign pend   = pend_q;
  assign disarm = disarm_q;

  p_cmd_drops_tx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_tx |=> !pend_q.tx && disarm_q);
  p_disarm_blocks_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    disarm_q && !pend_q.tx && tx_done |=> !pend_q.tx);
  p_data_arms_r5: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr && !rst_tx |=> !disarm_q);
  p_tx_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q.tx && !tx_ie |=> !pend_q.tx);
  p_rx_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clr |=> !pend_q.rx);
  p_ext_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_clr |=> !pend_q.ext);
endmodule

// File: rtl/sio_stat_read.sv
module sio_stat_read
  import sio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  src_pend_t         pend_a,
  input  src_pend_t         pend_b,
  input  logic              rd_chan,
  input  logic              master_ie,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  logic [STAT_W-1:0] packed_stat;
  logic              any_pend;

  assign packed_stat = pack_status(pend_a, pend_b);
  assign any_pend    = |packed_stat;
  assign status      = rd_chan ? '0 : packed_stat;
  assign irq         = master_ie && any_pend;

  p_spare_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    status[STAT_W-1:N_CH*SRC_W] == '0);
  p_chan_b_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_chan |-> status == '0);
  p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !master_ie |-> !irq);
endmodule

// File: rtl/sio_irq_pending.sv
module sio_irq_pending
  import sio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic              cmd_chan,
  input  logic [CMD_W-1:0]  cmd_code,
  input  logic [N_CH-1:0]   data_wr,
  input  logic [N_CH-1:0]   tx_done,
  input  logic [N_CH-1:0]   rx_evt,
  input  logic [N_CH-1:0]   ext_evt,
  input  logic [N_CH-1:0]   tx_ie,
  input  logic [N_CH-1:0]   rx_ie,
  input  logic [N_CH-1:0]   ext_ie,
  input  logic [N_CH-1:0]   rx_clr,
  input  logic [N_CH-1:0]   ext_clr,
  input  logic              master_ie,
  input  logic              rd_chan,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  logic [N_CH-1:0] rst_tx_hit;
  src_pend_t       pend [N_CH];
  logic [N_CH-1:0] disarm;

  sio_cmd_decode u_dec (
    .cmd_wr     (cmd_wr),
    .cmd_chan   (cmd_chan),
    .cmd_code   (cmd_code),
    .rst_tx_hit (rst_tx_hit)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    sio_chan_pend u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .tx_done (tx_done[c]),
      .tx_ie   (tx_ie[c]),
      .rx_evt  (rx_evt[c]),
      .rx_ie   (rx_ie[c]),
      .ext_evt (ext_evt[c]),
      .ext_ie  (ext_ie[c]),
      .rx_clr  (rx_clr[c]),
      .ext_clr (ext_clr[c]),
      .data_wr (data_wr[c]),
      .rst_tx  (rst_tx_hit[c]),
      .pend    (pend[c]),
      .disarm  (disarm[c])
    );
  end

  sio_stat_read u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend_a    (pend[0]),
    .pend_b    (pend[1]),
    .rd_chan   (rd_chan),
    .master_ie (master_ie),
    .status    (status),
    .irq       (irq)
  );

  p_one_chan_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rst_tx_hit) <= 1);
  p_reset_clear_r10: assert property (@(posedge clk)
    $rose(rst_n) |-> disarm == '0 && status == '0);
endmodule

// File: tb/tb_sio_irq_pending.sv
module tb_sio_irq_pending;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_wr = 0, cmd_chan = 0;
  logic [2:0] cmd_code = 0;
  logic [1:0] data_wr = 0, tx_done = 0, rx_evt = 0, ext_evt = 0;
  logic [1:0] tx_ie = 0, rx_ie = 0, ext_ie = 0, rx_clr = 0, ext_clr = 0;
  logic       master_ie = 0, rd_chan = 0;
  logic [7:0] status;
  logic       irq;

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model: per channel {rx, tx, ext} pending and disarm
  bit m_rx[2], m_tx[2], m_ext[2], m_dis[2];

  logic [7:0] q_stat[$];
  logic       q_irq[$];
  string      q_tag[$];

  always #2 clk = ~clk;

  sio_irq_pending dut (.*);

  function automatic logic [7:0] model_stat();
    logic [7:0] s;
    s = 8'h00;
    s[0] = m_ext[1]; s[1] = m_tx[1]; s[2] = m_rx[1];
    s[3] = m_ext[0]; s[4] = m_tx[0]; s[5] = m_rx[0];
    return s;
  endfunction

  task automatic chk(string tag, logic [7:0] act_s, logic [7:0] exp_s, logic act_i, logic exp_i);
    checks++;
    if (act_s !== exp_s || act_i !== exp_i) begin
      fails++;
      $display("FAIL %s status=%h/irq=%b expected status=%h/irq=%b", tag, act_s, act_i, exp_s, exp_i);
    end
  endtask

  // driver: inputs are already set at a negedge; advance model, push, clock
  task automatic cyc(string tag);
    bit hit;
    logic [7:0] s;
    for (int c = 0; c < 2; c++) begin
      hit = cmd_wr && (cmd_chan == c[0]) && (cmd_code == 3'b101);
      if (tx_done[c] && tx_ie[c] && !m_dis[c]) m_tx[c] = 1;
      if (hit) m_tx[c] = 0;
      if (rx_evt[c] && rx_ie[c]) m_rx[c] = 1;
      if (rx_clr[c]) m_rx[c] = 0;
      if (ext_evt[c] && ext_ie[c]) m_ext[c] = 1;
      if (ext_clr[c]) m_ext[c] = 0;
      if (data_wr[c]) m_dis[c] = 0;
      if (hit) m_dis[c] = 1;
    end
    s = model_stat();
    q_irq.push_back(master_ie && (s != 0));
    q_stat.push_back(rd_chan ? 8'h00 : s);
    q_tag.push_back(tag);
    @(negedge clk);
    cmd_wr = 0; data_wr = 0; tx_done = 0; rx_evt = 0; ext_evt = 0;
    rx_clr = 0; ext_clr = 0;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_stat.size() > 0)
        chk(q_tag.pop_front(), status, q_stat.pop_front(), irq, q_irq.pop_front());
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset", status, 8'h00, irq, 1'b0);
    rst_n = 1;
    @(negedge clk);
    chk("R10 after reset", status, 8'h00, irq, 1'b0);
    rx_ie = 2'b11; ext_ie = 2'b11; tx_ie = 2'b11; master_ie = 1;

    rx_evt = 2'b01; cyc("R7 R1 rx A");                 // 0x20
    rd_chan = 1; cyc("R2 read via B");                 // 0x00
    rd_chan = 0; ext_evt = 2'b10; cyc("R1 ext B");     // 0x21
    rx_ie = 2'b01; rx_evt = 2'b10; cyc("R7 rx B disabled");
    rx_ie = 2'b11;
    rx_evt = 2'b01; rx_clr = 2'b01; cyc("R8 rx A set+clear");
    ext_clr = 2'b10; cyc("R7 ext B clear");            // 0x00
    ext_evt = 2'b01; cyc("R1 ext A");                  // 0x08
    master_ie = 0; cyc("R9 master off");
    master_ie = 1; ext_clr = 2'b01; cyc("R9 none pending");
    tx_done = 2'b01; cyc("R6 tx A");                   // 0x10
    tx_ie = 2'b01; tx_done = 2'b10; cyc("R6 tx B disabled");
    tx_ie = 2'b11; tx_done = 2'b10; cyc("R6 R1 tx B"); // 0x12
    cmd_wr = 1; cmd_chan = 0; cmd_code = 3'b101; cyc("R3 reset tx A");
    tx_done = 2'b01; cyc("R4 disarmed tx A");
    cmd_wr = 1; cmd_chan = 1; cmd_code = 3'b100; cyc("R3 other code B");
    tx_done = 2'b01; cyc("R4 still disarmed A");
    data_wr = 2'b01; cyc("R5 data write A");
    tx_done = 2'b01; cyc("R5 rearmed tx A");           // 0x12
    cmd_wr = 1; cmd_chan = 0; cmd_code = 3'b101; data_wr = 2'b01; cyc("R5 cmd+data A");
    tx_done = 2'b01; cyc("R5 cmd wins A");
    cmd_wr = 1; cmd_chan = 1; cmd_code = 3'b101; tx_done = 2'b10; cyc("R8 tx B set+clear");
    data_wr = 2'b10; tx_done = 2'b10; cyc("R4 disarm read at edge B");
    tx_done = 2'b10; cyc("R6 tx B after arm");         // 0x02
    rd_chan = 1; cyc("R2 B read hides tx");
    rd_chan = 0; cyc("R1 final A read");
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    int n;
    n = 0;
    while (!done && n < 5000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule